// File: doc/BRIEF.md
# Centre-Aligned Complementary PWM Phase with Dead Time

This block drives one phase of a bridge. It produces two active-low switch commands, a high-side and a low-side, from a switching cycle that is split into two halves. A half counter runs on the peripheral clock. Each half takes three values from the input register set: a half length in clocks, a signed duty offset measured from the cycle centre, and a dead time. The high-side on-interval sits against the cycle centre. The low-side on-interval sits against the outer edges of the cycle. Dead time is taken off both on-times, so the two switches are never on together.

The input values are copied into working registers only at update boundaries. In single update mode that happens at the start of each cycle only. In double update mode it also happens at the cycle midpoint. The two halves can therefore differ in length, duty and dead time, and the waveform can be asymmetric. Two one-clock markers show the cycle start and the midpoint, so other logic can line up with the cycle.

Top module: `cpwm_phase`

## Requirements
- R1: While reset is asserted, and for the first clock after it is released, `hs_n` and `ls_n` are 1 (both off) and `sync_p` and `mid_p` are 0. The first cycle starts one clock after reset is released.
- R2: Each half lasts P clocks, where P is the captured half length (a captured value of 0 acts as 1). `sync_p` is 1 for exactly the first clock of the first half. `mid_p` is 1 for exactly the first clock of the second half. The two are never 1 together.
- R3: In each half, the high-side on-time is floor(P/2) + D − T clocks, clamped to the range 0 to P. D is the captured duty offset and T is the captured dead time.
- R4: In each half, the low-side on-time is floor(P/2) − D − T clocks, clamped to the range 0 to P.
- R5: In the first half, the high-side on-interval occupies the last clocks of the half and the low-side on-interval occupies the first clocks. In the second half, the high side is on in the first clocks and the low side is on in the last clocks.
- R6: When `dbl_mode` is 0 at the midpoint, the second half reuses the values captured at the cycle start.
- R7: When `dbl_mode` is 1 at the midpoint, the second half uses half length, duty offset and dead time freshly captured there, each independent of the first half.
- R8: Changes to `half_len`, `duty_ofs`, `dead` and `dbl_mode` between boundaries have no effect on the outputs until the next boundary.
- R9: Both outputs are active low (0 means the switch is on), and `hs_n` and `ls_n` are never 0 in the same clock.
- R10: `duty_ofs` is a 16-bit two's-complement value. A negative offset shortens the high-side on-time and lengthens the low-side on-time by the same amount. `half_len` and `dead` are unsigned.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_mode | input | 1 | 1 = also capture values at the midpoint |
| half_len | input | CW | Half length in clocks, unsigned |
| duty_ofs | input | DW | Duty offset from centre, two's complement |
| dead | input | CW | Dead time in clocks, unsigned |
| hs_n | output | 1 | High-side command, active low |
| ls_n | output | 1 | Low-side command, active low |
| sync_p | output | 1 | One-clock marker at cycle start |
| mid_p | output | 1 | One-clock marker at the midpoint |

## Verification
The hardest case to reach from the ports is a write that lands strictly between two boundaries. Such a write must leave the running half unchanged, and the next boundary must capture the restored value. The driver watches the boundary markers. Two clocks into a chosen half, it writes wild values to every input, then restores them one clock later, and the scoreboard confirms that both that half and the next match the undisturbed prediction. Clamping at both ends, dead time longer than half a half, odd and zero lengths, and mode changes at the midpoint are reached by stepping the inputs at each boundary marker.

// File: rtl/cpwm_phase.sv
module cpwm_phase #(
  parameter int CW = 16,
  parameter int DW = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 dbl_mode,
  input  logic [CW-1:0]        half_len,
  input  logic signed [DW-1:0] duty_ofs,
  input  logic [CW-1:0]        dead,
  output logic                 hs_n,
  output logic                 ls_n,
  output logic                 sync_p,
  output logic                 mid_p
);
  localparam int SW = ((CW > DW) ? CW : DW) + 3;

  logic [CW-1:0]        cnt, wp, wt;
  logic signed [DW-1:0] wd;
  logic                 half, started;

  wire last = (cnt == wp - CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt     <= '0;
      half    <= 1'b1;
      started <= 1'b0;
      wp      <= CW'(1);
      wd      <= '0;
      wt      <= '0;
    end else if (last) begin
      cnt     <= '0;
      half    <= ~half;
      started <= 1'b1;
      if (half || dbl_mode) begin
        wp <= (half_len == '0) ? CW'(1) : half_len;
        wd <= duty_ofs;
        wt <= dead;
      end
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  logic signed [SW-1:0] p_s, c_s, d_s, t_s, hs_raw, ls_raw;
  assign p_s    = SW'(wp);
  assign c_s    = SW'(wp >> 1);
  assign d_s    = SW'(wd);
  assign t_s    = SW'(wt);
  assign hs_raw = c_s + d_s - t_s;
  assign ls_raw = c_s - d_s - t_s;

  function automatic logic [CW-1:0] clamp(input logic signed [SW-1:0] v,
                                          input logic signed [SW-1:0] lim);
    if (v < 0)        return '0;
    else if (v > lim) return lim[CW-1:0];
    else              return v[CW-1:0];
  endfunction

  logic [CW-1:0] hs_on, ls_on;
  assign hs_on = clamp(hs_raw, p_s);
  assign ls_on = clamp(ls_raw, p_s);

  logic hs_act, ls_act;
  assign hs_act = half ? (cnt < hs_on) : (cnt >= wp - hs_on);
  assign ls_act = half ? (cnt >= wp - ls_on) : (cnt < ls_on);

  assign hs_n   = ~(started & hs_act);
  assign ls_n   = ~(started & ls_act);
  assign sync_p = started & ~half & (cnt == '0);
  assign mid_p  = started &  half & (cnt == '0);
endmodule

// File: rtl/cpwm_phase_chk.sv
module cpwm_phase_chk (
  input logic clk,
  input logic rst_n,
  input logic hs_n,
  input logic ls_n,
  input logic sync_p,
  input logic mid_p
);
  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!hs_n && !ls_n));

  p_marks_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(sync_p && mid_p));

  p_sync_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_p |=> !sync_p);

  p_mid_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mid_p |=> !mid_p);

  p_off_after_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (hs_n && ls_n && !sync_p && !mid_p));
endmodule

bind cpwm_phase cpwm_phase_chk u_chk (.*);

// File: tb/tb_cpwm_phase.sv
module tb_cpwm_phase;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    bit    first;
    int    p;
    int    hs;
    int    ls;
    string tag;
  } item_t;

  logic clk = 0, rst_n = 0, dbl_mode = 0;
  logic [15:0] half_len = 0, dead = 0;
  logic signed [15:0] duty_ofs = 0;
  logic hs_n, ls_n, sync_p, mid_p;

  int checks = 0, errors = 0;
  bit done = 0;
  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cpwm_phase dut (.*);

  task automatic get_stim(input int k, output bit dbl, output int p, output int d,
                          output int t, output bit junk, output string tag);
    junk = 0;
    case (k)
      0:  begin dbl=0; p=20; d=0;   t=2; tag="R6 base"; end
      1:  begin dbl=0; p=20; d=3;   t=1; tag="R6 offset"; end
      2:  begin dbl=0; p=21; d=-4;  t=2; tag="R10 negative odd"; end
      3:  begin dbl=0; p=21; d=-4;  t=2; tag="R10 negative odd"; end
      4:  begin dbl=1; p=16; d=2;   t=1; tag="R7 double"; end
      5:  begin dbl=1; p=30; d=-5;  t=3; tag="R7 asym"; end
      6:  begin dbl=1; p=12; d=20;  t=0; tag="R3 clamp high"; end
      7:  begin dbl=1; p=12; d=-20; t=0; tag="R4 clamp low"; end
      8:  begin dbl=1; p=10; d=0;   t=8; tag="R3 R4 dead exceeds"; end
      9:  begin dbl=1; p=24; d=1;   t=2; junk=1; tag="R8 junk write"; end
      10: begin dbl=1; p=24; d=1;   t=2; tag="R8 after junk"; end
      11: begin dbl=1; p=0;  d=0;   t=0; tag="R2 zero length"; end
      12: begin dbl=1; p=1;  d=0;   t=0; tag="R2 unit length"; end
      13: begin dbl=0; p=15; d=2;   t=1; tag="R6 single"; end
      14: begin dbl=0; p=40; d=-7;  t=4; tag="R6 mid write ignored"; end
      15: begin dbl=0; p=40; d=-7;  t=4; tag="R6 wide"; end
      16: begin dbl=1; p=9;  d=0;   t=0; tag="R5 no dead"; end
      default: begin dbl=1; p=9; d=3; t=0; tag="R5 shifted"; end
    endcase
  endtask

  function automatic int clampi(int v, int lim);
    if (v < 0) return 0;
    if (v > lim) return lim;
    return v;
  endfunction

  localparam int NSTEPS = 18;

  initial begin : driver
    bit dbl, junk;
    int p, d, t, k;
    int lp, ld, lt;
    string tag, ltag;
    item_t it;
    get_stim(0, dbl, p, d, t, junk, tag);
    dbl_mode = dbl; half_len = 16'(p); duty_ofs = 16'(d); dead = 16'(t);
    lp = 0; ld = 0; lt = 0; ltag = "";
    repeat (5) @(negedge clk);
    checks++;
    if (!(hs_n && ls_n && !sync_p && !mid_p)) begin
      errors++;
      $display("FAIL R1 reset state: hs_n=%b ls_n=%b sync=%b mid=%b expected 1 1 0 0",
               hs_n, ls_n, sync_p, mid_p);
    end
    rst_n = 1;
    checks++;
    if (!(hs_n && ls_n && !sync_p && !mid_p)) begin
      errors++;
      $display("FAIL R1 at release: hs_n=%b ls_n=%b sync=%b mid=%b expected 1 1 0 0",
               hs_n, ls_n, sync_p, mid_p);
    end
    @(negedge clk);
    checks++;
    if (sync_p !== 1'b1) begin
      errors++;
      $display("FAIL R1 first cycle start: sync_p=%b expected 1", sync_p);
    end
    k = 1;
    while (k <= NSTEPS + 1) begin
      if (sync_p || mid_p) begin
        if (sync_p || dbl_mode) begin
          lp = (half_len == 0) ? 1 : int'(half_len);
          ld = int'(duty_ofs);
          lt = int'(dead);
          ltag = tag;
        end
        it.first = sync_p;
        it.p  = lp;
        it.hs = clampi(lp/2 + ld - lt, lp);
        it.ls = clampi(lp/2 - ld - lt, lp);
        it.tag = ltag;
        q.push_back(it);
        get_stim(k, dbl, p, d, t, junk, tag);
        dbl_mode = dbl; half_len = 16'(p); duty_ofs = 16'(d); dead = 16'(t);
        k++;
        if (junk) begin
          @(negedge clk);
          @(negedge clk);
          dbl_mode = ~dbl; half_len = 16'd3; duty_ofs = -16'sd300; dead = 16'd999;
          @(negedge clk);
          dbl_mode = dbl; half_len = 16'(p); duty_ofs = 16'(d); dead = 16'(t);
        end
      end
      @(negedge clk);
    end
    done = 1;
  end

  bit collecting = 0;
  bit rec_first;
  int idx;
  bit rec_hs[256];
  bit rec_ls[256];

  always @(negedge clk) begin : monitor
    if (rst_n) begin
      if (sync_p || mid_p) begin
        if (collecting) begin
          item_t e;
          bit bad;
          int hs_cnt, ls_cnt;
          e = q.pop_front();
          bad = (e.first != rec_first) || (idx != e.p);
          hs_cnt = 0; ls_cnt = 0;
          for (int i = 0; i < idx && i < 256; i++) begin
            bit xh, xl;
            hs_cnt += rec_hs[i]; ls_cnt += rec_ls[i];
            xh = e.first ? (i >= e.p - e.hs) : (i < e.hs);
            xl = e.first ? (i < e.ls) : (i >= e.p - e.ls);
            if (xh != rec_hs[i] || xl != rec_ls[i]) bad = 1;
          end
          checks++;
          if (bad) begin
            errors++;
            $display("FAIL R2 R3 R4 R5 R9 [%s] first=%0b: got len=%0d hs_on=%0d ls_on=%0d first=%0b, expected len=%0d hs_on=%0d ls_on=%0d",
                     e.tag, e.first, idx, hs_cnt, ls_cnt, rec_first, e.p, e.hs, e.ls);
          end
        end
        collecting = 1;
        idx = 0;
        rec_first = sync_p;
      end
      if (collecting && idx < 256) begin
        rec_hs[idx] = !hs_n;
        rec_ls[idx] = !ls_n;
      end
      if (collecting) idx++;
    end
  end

  initial begin : watchdog
    int n;
    n = 0;
    while (!done && n < 20000) begin
      @(posedge clk);
      n++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, got %0d cycles expected completion", n);
    end
    repeat (3) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule